// File: doc/BRIEF.md
# Packed Float/Integer Saturating Converter

This block turns a 64-bit word that holds two 32-bit lanes into a 64-bit result. Each lane is converted in one of four directions, picked by a 2-bit mode. The first two directions take single-precision floats and produce integers. One produces a full 32-bit integer. The other produces a 16-bit integer, sign-extended to fill the 32-bit lane. Both clamp out-of-range values to fixed limits. The other two directions produce single-precision floats. One reads each 32-bit lane as a signed integer. The other reads only the signed low half-word of each lane.

A conversion starts when `in_valid` is high at a rising clock edge. The result and `out_valid` appear on the register outputs after that edge. In a cycle without a request, `out_valid` is low and `result` keeps its last value. Exception flags are not produced. A NaN payload is not carried through. Subnormal floats are read as zero.

Top module: `packed_cvt_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `out_valid` is 0 and `result` is all zeros.
- R2: A request with `in_valid`=1 at a clock edge makes `out_valid`=1 after that edge. A cycle with `in_valid`=0 makes `out_valid`=0 and leaves `result` unchanged.
- R3: Mode 0 (float to int32): an in-range lane gives its value truncated toward zero, as a two's-complement 32-bit integer in the same lane.
- R4: Mode 0: a lane at or above 2^31 gives 0x7FFF_FFFF, including +infinity. A lane at or below -2^31 gives 0x8000_0000, including -infinity.
- R5: Mode 1 (float to int16): an in-range lane gives its value truncated toward zero, sign-extended to 32 bits in the same lane.
- R6: Mode 1: a lane at or above 2^15 gives 0x0000_7FFF. A lane at or below -2^15 gives 0xFFFF_8000.
- R7: In modes 0 and 1, a NaN lane gives that mode's negative limit. A lane with exponent field 0 (zero or subnormal) gives 0.
- R8: Mode 2 (int32 to float): each lane is read as a signed 32-bit integer. It is converted exactly when it fits in 24 significant bits. Otherwise it is rounded to nearest, and a tie goes to the even mantissa. Zero gives 0x0000_0000.
- R9: Mode 3 (int16 to float): bits [15:0] give result [31:0] and bits [47:32] give result [63:32]. Each is read as a signed 16-bit integer. Bits [31:16] and [63:48] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Conversion request |
| mode | input | 2 | 0 float→int32, 1 float→int16, 2 int32→float, 3 int16→float |
| src | input | 64 | Two packed 32-bit source lanes |
| out_valid | output | 1 | Result register holds a new conversion |
| result | output | 64 | Two packed 32-bit converted lanes |

## Verification
The bench aims at the limit edges: exactly ±2^31 and ±2^15, the largest float just below 2^31, infinities and NaN. A design that used the wrong limit exponent, or sent NaN to the positive limit, would give a lane off by one limit or of the wrong sign. Fractions such as ±1.5 and 0.75 expose a design that rounds instead of truncating. Integers just over 2^24, with ties and non-ties, expose missing round-to-even. Differences only in the ignored upper half-words of mode 3 expose a design that reads the wrong bits or fails to sign-extend.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int LANE_W = 32;

  typedef enum logic [1:0] {
    CVT_F2I32 = 2'd0,
    CVT_F2I16 = 2'd1,
    CVT_I32F  = 2'd2,
    CVT_I16F  = 2'd3
  } cvt_mode_e;

  // Float lane to integer, truncating toward zero, with saturation.
  function automatic logic [31:0] f2i_lane(input logic [31:0] f, input logic narrow);
    logic        s;
    logic [7:0]  e;
    logic [22:0] m;
    logic [31:0] pos_lim, neg_lim, mag;
    logic [7:0]  lim_exp;
    s       = f[31];
    e       = f[30:23];
    m       = f[22:0];
    pos_lim = narrow ? 32'h0000_7FFF : 32'h7FFF_FFFF;
    neg_lim = narrow ? 32'hFFFF_8000 : 32'h8000_0000;
    lim_exp = narrow ? 8'd142 : 8'd158;
    if (e == 8'hFF) return (m != 23'd0 || s) ? neg_lim : pos_lim;
    if (e < 8'd127) return 32'd0;
    if (e >= lim_exp) return s ? neg_lim : pos_lim;
    if (e >= 8'd150) mag = {8'd0, 1'b1, m} << (e - 8'd150);
    else             mag = {8'd0, 1'b1, m} >> (8'd150 - e);
    return s ? (~mag + 32'd1) : mag;
  endfunction

  // Signed 32-bit integer to float, round to nearest even.
  function automatic logic [31:0] i2f_lane(input logic [31:0] x);
    logic        s;
    logic [31:0] mag, rem, half;
    logic [24:0] keep;
    logic [7:0]  e;
    int          p, sh;
    if (x == 32'd0) return 32'd0;
    s   = x[31];
    mag = s ? (~x + 32'd1) : x;
    p   = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    e = 8'(127 + p);
    if (p <= 23) begin
      mag = mag << (23 - p);
      return {s, e, mag[22:0]};
    end
    sh   = p - 23;
    keep = 25'(mag >> sh);
    rem  = mag & ((32'd1 << sh) - 32'd1);
    half = 32'd1 << (sh - 1);
    if (rem > half || (rem == half && keep[0])) keep = keep + 25'd1;
    if (keep[24]) begin
      e    = e + 8'd1;
      keep = keep >> 1;
    end
    return {s, e, keep[22:0]};
  endfunction
endpackage

// File: rtl/cvt_lane.sv
module cvt_lane
  import cvt_pkg::*;
(
  input  logic [LANE_W-1:0] lane_src,
  input  logic [1:0]        mode,
  output logic [LANE_W-1:0] lane_res
);
  logic [LANE_W-1:0] half_sext;
  assign half_sext = {{(LANE_W-16){lane_src[15]}}, lane_src[15:0]};

  always_comb begin
    unique case (cvt_mode_e'(mode))
      CVT_F2I32: lane_res = f2i_lane(lane_src, 1'b0);
      CVT_F2I16: lane_res = f2i_lane(lane_src, 1'b1);
      CVT_I32F:  lane_res = i2f_lane(lane_src);
      CVT_I16F:  lane_res = i2f_lane(half_sext);
      default:   lane_res = '0;
    endcase
  end
endmodule

// File: rtl/cvt_out_reg.sv
module cvt_out_reg #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic             vld,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/packed_cvt_unit.sv
module packed_cvt_unit
  import cvt_pkg::*;
#(
  parameter int LANES = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] src,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] conv_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cvt_lane u_lane (
      .lane_src (src[g*LANE_W +: LANE_W]),
      .mode     (mode),
      .lane_res (conv_word[g*LANE_W +: LANE_W])
    );
  end

  cvt_out_reg #(.WIDTH(WORD_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (conv_word),
    .vld   (out_valid),
    .q     (result)
  );
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  mode,
  input logic [63:0] src,
  input logic        out_valid,
  input logic [63:0] result
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_nan_neg_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0 && src[30:23] == 8'hFF && src[22:0] != 23'd0)
      |=> result[31:0] == 32'h8000_0000);

  assert_narrow_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1) |=>
      ((result[31:15] == 17'd0 || result[31:15] == 17'h1FFFF) &&
       (result[63:47] == 17'd0 || result[63:47] == 17'h1FFFF)));

  assert_zero_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && src[63:32] == 32'd0) |=> result[63:32] == 32'd0);

  assert_half_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3 && src[15:0] == 16'd0) |=> result[31:0] == 32'd0);
endmodule

bind packed_cvt_unit cvt_checker u_cvt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .src       (src),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/test_packed_cvt_unit.sv
`timescale 1ns/1ps
module test_packed_cvt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [63:0] src = 64'd0;
  logic        out_valid;
  logic [63:0] result;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  packed_cvt_unit i_packed_cvt_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .src(src), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] ref_f2i(input logic [31:0] f, input bit narrow);
    real v, lim;
    logic [31:0] pos, neg;
    pos = narrow ? 32'h0000_7FFF : 32'h7FFF_FFFF;
    neg = narrow ? 32'hFFFF_8000 : 32'h8000_0000;
    if (f[30:23] == 8'hFF) return (f[22:0] != 0 || f[31]) ? neg : pos;
    if (f[30:23] == 8'h00) return 32'd0;
    v = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (real'(int'(f[30:23])) - 127.0));
    if (f[31]) v = -v;
    lim = narrow ? 32768.0 : 2147483648.0;
    if (v >= lim) return pos;
    if (v <= -lim) return neg;
    return 32'($rtoi(v));
  endfunction

  function automatic logic [31:0] ref_i2f(input logic [31:0] x);
    longint v, m;
    bit     s, rb, st;
    int     e;
    v  = longint'($signed(x));
    s  = (v < 0);
    m  = s ? -v : v;
    e  = 150;
    rb = 1'b0;
    st = 1'b0;
    if (m == 0) return 32'd0;
    while (m >= 64'd16777216) begin
      st = st | rb;
      rb = m[0];
      m  = m >> 1;
      e++;
    end
    if (rb && (st || m[0])) m++;
    if (m == 64'd16777216) begin m = m >> 1; e++; end
    while (m < 64'd8388608) begin m = m << 1; e--; end
    return {s, e[7:0], m[22:0]};
  endfunction

  function automatic logic [31:0] ref_lane(input logic [31:0] x, input logic [1:0] md);
    case (md)
      2'd0:    return ref_f2i(x, 1'b0);
      2'd1:    return ref_f2i(x, 1'b1);
      2'd2:    return ref_i2f(x);
      default: return ref_i2f({{16{x[15]}}, x[15:0]});
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register later)
  task automatic convert(input string req, input logic [1:0] md, input logic [63:0] s);
    logic [63:0] exp;
    exp = {ref_lane(s[63:32], md), ref_lane(s[31:0], md)};
    @(negedge clk);
    mode = md; src = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid", {63'd0, out_valid}, 64'd1);
    check(req, result, exp);
  endtask

  function automatic logic [31:0] rnd_float();
    logic [31:0] r;
    r = $urandom;
    r[30:23] = 8'(100 + ($urandom % 70));
    return r;
  endfunction

  function automatic logic [31:0] rnd_int();
    logic [31:0] r;
    r = $urandom;
    return $signed(r) >>> ($urandom % 32);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {63'd0, out_valid} | result, 64'd0);

    // R3 truncation in mode 0
    convert("R3", 2'd0, {32'hBFC0_0000, 32'h3FC0_0000});
    check("R3 literal", result, {32'hFFFF_FFFF, 32'h0000_0001});
    convert("R3", 2'd0, {32'h4EFF_FFFF, 32'h3F40_0000});
    check("R3 literal big", result, {32'h7FFF_FF80, 32'h0000_0000});
    // R4 limits
    convert("R4", 2'd0, {32'hCF00_0000, 32'h4F00_0000});
    check("R4 literal", result, {32'h8000_0000, 32'h7FFF_FFFF});
    convert("R4", 2'd0, {32'hFF80_0000, 32'h7F80_0000});
    check("R4 inf", result, {32'h8000_0000, 32'h7FFF_FFFF});
    // R5/R6 narrow
    convert("R5", 2'd1, {32'hC2C9_6666, 32'h46FF_FE00});
    check("R5 literal", result, {32'hFFFF_FF9C, 32'h0000_7FFF});
    convert("R6", 2'd1, {32'hC700_0000, 32'h4700_0000});
    check("R6 literal", result, {32'hFFFF_8000, 32'h0000_7FFF});
    convert("R6", 2'd1, {32'hC780_0000, 32'h5000_0000});
    // R7 NaN and subnormal
    convert("R7", 2'd0, {32'h0000_0001, 32'h7FC0_0000});
    check("R7 literal", result, {32'h0000_0000, 32'h8000_0000});
    convert("R7", 2'd1, {32'h807F_FFFF, 32'hFFC0_0001});
    check("R7 narrow", result, {32'h0000_0000, 32'hFFFF_8000});
    // R8 rounding
    convert("R8", 2'd2, {32'h0100_0003, 32'h0100_0001});
    check("R8 ties", result, {32'h4B80_0002, 32'h4B80_0000});
    convert("R8", 2'd2, {32'h8000_0000, 32'h7FFF_FFFF});
    check("R8 extremes", result, {32'hCF00_0000, 32'h4F00_0000});
    convert("R8", 2'd2, {32'h0000_0000, 32'hFFFF_FFFF});
    check("R8 zero", result, {32'h0000_0000, 32'hBF80_0000});
    // R9 upper half-words ignored
    convert("R9", 2'd3, {32'h0000_8000, 32'h0000_0005});
    held = result;
    convert("R9", 2'd3, {32'hABCD_8000, 32'h1234_0005});
    check("R9 ignore upper", result, held);
    check("R9 literal", result, {32'hC700_0000, 32'h40A0_0000});

    // R2 hold while idle
    held = result;
    @(negedge clk);
    src = ~src; mode = 2'd0;
    @(negedge clk);
    check("R2 idle valid", {63'd0, out_valid}, 64'd0);
    check("R2 idle hold", result, held);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      md = 2'($urandom % 4);
      case (md)
        2'd0: convert("R3 R4 random", md, {rnd_float(), rnd_float()});
        2'd1: convert("R5 R6 random", md, {rnd_float(), rnd_float()});
        2'd2: convert("R8 random", md, {rnd_int(), rnd_int()});
        default: convert("R9 random", md, {$urandom, $urandom});
      endcase
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule